// File: doc/BRIEF.md
# Burst Read Address Sequencer

The sequencer turns one burst request into the stream of word addresses that a synchronous memory array reads during a burst. A request carries a start address, a 3-bit burst-length code and a mode bit. The sequencer then presents one address at a time on a valid/ready output stream. Each accepted address advances the burst by one word.

A fixed burst of 4, 8 or 16 words runs in one of two ways. In wrap mode the word offset cycles inside the aligned group whose size is the burst length. In linear mode the address counts straight up past group boundaries. A continuous code gives an open-ended linear burst, which ends only when the chip enable goes inactive.

Alongside each new address the block raises a one-cycle fetch-request flag when the array must load a fresh internal row. This happens at the start of every burst. In linear and continuous bursts it also happens each time the address steps into a new aligned group. A one-cycle done flag marks the end of a fixed burst.

Back-pressure rules:
- The request side is held off whenever a burst is running or the chip enable is inactive.
- The address side may stall at any time. While it stalls, the presented address and its flags stay put.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_valid`, `fetch_req` and `burst_done` are 0. With `chip_en_n` low, `start_ready` is 1.
- R2: A request is taken on a clock edge where `start_valid` and `start_ready` are both 1. `start_ready` is 1 only when no burst is running and `chip_en_n` is low. The mode and length code are captured at that edge, so later changes to them do not affect the running burst. The first address, equal to `start_addr`, is valid in the next cycle. A request presented while `chip_en_n` is high is not taken.
- R3: While `addr_valid` is 1 and `addr_ready` is 0, `addr_out` and `addr_valid` hold, and `fetch_req` is 0 after the first stalled cycle.
- R4: Length codes: 3'b001 is 4 words, 3'b010 is 8 words, 3'b011 is 16 words and 3'b111 is continuous. Every other code (000, 100, 101, 110) is treated as 4 words.
- R5: With `cfg_linear` = 0 and a fixed length L, each accepted address steps its low log2(L) bits by one modulo L. The bits above them stay fixed. Example: start 2 with L=4 gives 2,3,0,1.
- R6: With `cfg_linear` = 1 and a fixed length L, the addresses are start, start+1, …, start+L-1. Example: start 3 with L=4 gives 3,4,5,6.
- R7: With code 3'b111 the address counts up by one per accepted word, whatever `cfg_linear` is. No done flag is raised.
- R8: In the cycle after the last word of a fixed burst is accepted, `burst_done` is 1 for one cycle, `addr_valid` is 0 and `start_ready` is 1.
- R9: `fetch_req` is 1 in the cycle the first address of a burst becomes valid.
- R10: In linear or continuous bursts, `fetch_req` is 1 in the first cycle of every later address whose offset within its group is 0. The group is L words for fixed lengths and 4 words for continuous. In wrap bursts, `fetch_req` is raised only at the start.
- R11: `chip_en_n` high for one edge ends any burst. In the next cycle `addr_valid` and `burst_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en_n | input | 1 | Active-low chip enable; high ends the burst |
| cfg_linear | input | 1 | 0 = wrap within group, 1 = linear |
| cfg_len | input | 3 | Burst-length code |
| start_valid | input | 1 | Burst request valid |
| start_ready | output | 1 | Burst request can be taken |
| start_addr | input | ADDR_W | First word address |
| addr_valid | output | 1 | `addr_out` holds a burst address |
| addr_ready | input | 1 | Consumer takes the current address |
| addr_out | output | ADDR_W | Current word address |
| fetch_req | output | 1 | Array must fetch a new internal row |
| burst_done | output | 1 | Fixed burst completed (one-cycle pulse) |

## Verification
The checker makes several assumptions about the inputs:
- Addresses stay below the top of the address space, so a linear step never wraps through zero.
- Upper address bits above bit 3 are compared only in wrap bursts, whose groups never exceed 16 words.
- `chip_en_n` is a synchronous level sampled at the same edge as the handshakes.

The directed tasks keep to these assumptions by several means:
- Start addresses are drawn from the low few hundred words.
- The consumer's ready and the chip enable change only at falling edges.
- Requests are raised only when a fresh burst is wanted.
- The request fields are scrambled right after acceptance, which checks that they were captured at the handshake.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LEN_LOG_MAX = 4;

  localparam logic [2:0] LEN_CODE_4    = 3'b001;
  localparam logic [2:0] LEN_CODE_8    = 3'b010;
  localparam logic [2:0] LEN_CODE_16   = 3'b011;
  localparam logic [2:0] LEN_CODE_CONT = 3'b111;

  typedef struct packed {
    logic                   cont;     // open-ended linear burst
    logic                   wrap;     // offset wraps inside the group
    logic [2:0]             grp_log;  // log2 of group size
    logic [LEN_LOG_MAX-1:0] beats_m1; // words in burst minus one
  } burst_cfg_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int CONT_GRP_LOG = 2
) (
  input  logic       linear,
  input  logic [2:0] len_code,
  output burst_cfg_t cfg
);
  always_comb begin
    cfg.cont = 1'b0;
    cfg.wrap = ~linear;
    unique case (len_code)
      LEN_CODE_8: begin
        cfg.grp_log  = 3'd3;
        cfg.beats_m1 = LEN_LOG_MAX'(7);
      end
      LEN_CODE_16: begin
        cfg.grp_log  = 3'd4;
        cfg.beats_m1 = LEN_LOG_MAX'(15);
      end
      LEN_CODE_CONT: begin
        cfg.cont     = 1'b1;
        cfg.wrap     = 1'b0;
        cfg.grp_log  = 3'(CONT_GRP_LOG);
        cfg.beats_m1 = '1;
      end
      default: begin // 4-word code and all reserved codes
        cfg.grp_log  = 3'd2;
        cfg.beats_m1 = LEN_LOG_MAX'(3);
      end
    endcase
  end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  burst_cfg_t        cfg,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              grp_enter
);
  logic [ADDR_W-1:0] grp_mask;
  logic [ADDR_W-1:0] inc_addr;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    if (g < 8) begin : g_low
      assign grp_mask[g] = (cfg.grp_log > 3'(g));
    end else begin : g_high
      assign grp_mask[g] = 1'b0;
    end
  end

  assign inc_addr = cur_addr + ADDR_W'(1);

  always_comb begin
    if (cfg.wrap) nxt_addr = (cur_addr & ~grp_mask) | (inc_addr & grp_mask);
    else          nxt_addr = inc_addr;
    grp_enter = ~cfg.wrap && ((nxt_addr & grp_mask) == '0);
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             at_last
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     remain_q <= '0;
    else if (load)  remain_q <= load_val;
    else if (step)  remain_q <= remain_q - CNT_W'(1);
  end

  assign at_last = (remain_q == '0);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CONT_GRP_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              cfg_linear,
  input  logic [2:0]        cfg_len,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              fetch_req,
  output logic              burst_done
);
  burst_cfg_t        dec_cfg;
  burst_cfg_t        cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] nxt_addr;
  logic              grp_enter;
  logic              valid_q, fetch_q, done_q;
  logic              accept, take, cnt_last, last_beat, wrap_act;

  burst_len_decode #(.CONT_GRP_LOG(CONT_GRP_LOG)) u_dec (
    .linear   (cfg_linear),
    .len_code (cfg_len),
    .cfg      (dec_cfg)
  );

  burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr  (addr_q),
    .cfg       (cfg_q),
    .nxt_addr  (nxt_addr),
    .grp_enter (grp_enter)
  );

  burst_beat_cnt #(.CNT_W(LEN_LOG_MAX)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (dec_cfg.beats_m1),
    .step     (take),
    .at_last  (cnt_last)
  );

  assign start_ready = ~valid_q & ~chip_en_n;
  assign accept      = start_valid & start_ready;
  assign take        = valid_q & addr_ready;
  assign last_beat   = cnt_last & ~cfg_q.cont;
  assign wrap_act    = cfg_q.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fetch_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      cfg_q   <= '0;
    end else if (chip_en_n) begin
      valid_q <= 1'b0;
      fetch_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (accept) begin
      valid_q <= 1'b1;
      fetch_q <= 1'b1;
      done_q  <= 1'b0;
      addr_q  <= start_addr;
      cfg_q   <= dec_cfg;
    end else if (take) begin
      if (last_beat) begin
        valid_q <= 1'b0;
        fetch_q <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        addr_q  <= nxt_addr;
        fetch_q <= grp_enter;
        done_q  <= 1'b0;
      end
    end else begin
      fetch_q <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  assign addr_valid = valid_q;
  assign addr_out   = addr_q;
  assign fetch_req  = fetch_q;
  assign burst_done = done_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic              fetch_req,
  input logic              burst_done,
  input logic              wrap_act,
  input logic              last_beat
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !chip_en_n) |=> (addr_valid && $stable(addr_out))); // R3
  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (addr_valid && fetch_req)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!addr_valid && start_ready == !chip_en_n)); // R8
  AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && wrap_act && !last_beat && !chip_en_n)
    |=> (addr_out[ADDR_W-1:4] == $past(addr_out[ADDR_W-1:4]))); // R5
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && !wrap_act && !last_beat && !chip_en_n)
    |=> (addr_out == $past(addr_out) + ADDR_W'(1))); // R6
  AST_CE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en_n |=> (!addr_valid && !burst_done)); // R11
  AST_FETCH_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> addr_valid); // R10
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_en_n   (chip_en_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .addr_valid  (addr_valid),
  .addr_ready  (addr_ready),
  .addr_out    (addr_out),
  .fetch_req   (fetch_req),
  .burst_done  (burst_done),
  .wrap_act    (wrap_act),
  .last_beat   (last_beat)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chip_en_n = 1'b0;
  logic              cfg_linear = 1'b0;
  logic [2:0]        cfg_len = 3'b001;
  logic              start_valid = 1'b0;
  logic              start_ready;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              addr_valid;
  logic              addr_ready = 1'b0;
  logic [ADDR_W-1:0] addr_out;
  logic              fetch_req;
  logic              burst_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n),
    .cfg_linear(cfg_linear), .cfg_len(cfg_len),
    .start_valid(start_valid), .start_ready(start_ready), .start_addr(start_addr),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .fetch_req(fetch_req), .burst_done(burst_done)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b010:  return 8;
      3'b011:  return 16;
      default: return 4;
    endcase
  endfunction

  // one burst: request, walk all words (optional stalls), check the end
  task automatic run_burst(input bit linear, input logic [2:0] code, input int start,
                           input int beats, input bit stall, input string req);
    bit cont = (code == 3'b111);
    int len  = cont ? beats : len_of(code);
    int grp  = cont ? 4 : len;
    bit wrap = !linear && !cont;
    @(negedge clk);
    cfg_linear = linear; cfg_len = code; start_addr = ADDR_W'(start);
    start_valid = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    start_valid = 1'b0;
    cfg_linear = ~linear; cfg_len = 3'b011; start_addr = 16'h5555; // R2 sampled at accept
    for (int i = 0; i < len; i++) begin
      int ea = wrap ? ((start & ~(len - 1)) | ((start + i) & (len - 1))) : (start + i);
      int ef = (i == 0) || (!wrap && (ea % grp) == 0);
      check(int'(addr_valid), 1, req, "addr_valid during burst");
      check(int'(addr_out), ea, req, "address");
      check(int'(fetch_req), ef, (i == 0) ? "R9" : "R10", "fetch_req");
      if (stall && (i % 3 == 1)) begin
        @(negedge clk);
        check(int'(addr_out), ea, "R3", "held address under stall");
        check(int'(fetch_req), 0, "R3", "fetch_req under stall");
      end
      addr_ready = 1'b1;
      @(negedge clk);
      addr_ready = 1'b0;
    end
    if (!cont) begin
      check(int'(burst_done), 1, "R8", "done pulse");
      check(int'(addr_valid), 0, "R8", "valid after last");
      check(int'(start_ready), 1, "R8", "ready after last");
      @(negedge clk);
      check(int'(burst_done), 0, "R8", "done is one cycle");
    end
  endtask

  task automatic test_reset();
    check(int'(addr_valid), 0, "R1", "reset addr_valid");
    check(int'(fetch_req), 0, "R1", "reset fetch_req");
    check(int'(burst_done), 0, "R1", "reset burst_done");
    check(int'(start_ready), 1, "R1", "reset start_ready");
  endtask

  task automatic test_four_word_all_offsets();
    for (int off = 0; off < 4; off++) begin
      run_burst(1'b0, 3'b001, 16'h120 + off, 0, 1'b0, "R5");
      run_burst(1'b1, 3'b001, 16'h120 + off, 0, 1'b0, "R6");
    end
  endtask

  task automatic test_long_lengths();
    run_burst(1'b0, 3'b010, 16'h045, 0, 1'b1, "R4 R5");
    run_burst(1'b1, 3'b010, 16'h045, 0, 1'b1, "R4 R6");
    run_burst(1'b0, 3'b011, 16'h03A, 0, 1'b0, "R4 R5");
    run_burst(1'b1, 3'b011, 16'h03A, 0, 1'b1, "R4 R6");
  endtask

  task automatic test_reserved_codes();
    run_burst(1'b0, 3'b000, 16'h082, 0, 1'b0, "R4");
    run_burst(1'b1, 3'b101, 16'h082, 0, 1'b0, "R4");
    run_burst(1'b0, 3'b110, 16'h083, 0, 1'b0, "R4");
  endtask

  task automatic test_continuous();
    run_burst(1'b0, 3'b111, 16'h07E, 12, 1'b1, "R7");
    check(int'(addr_valid), 1, "R7", "continuous keeps running");
    check(int'(burst_done), 0, "R7", "no done in continuous");
    chip_en_n = 1'b1;
    @(negedge clk);
    check(int'(addr_valid), 0, "R11", "valid after chip enable off");
    check(int'(burst_done), 0, "R11", "no done on abort");
    check(int'(start_ready), 0, "R2", "not ready with chip enable off");
    chip_en_n = 1'b0;
    @(negedge clk);
    check(int'(start_ready), 1, "R2", "ready again");
  endtask

  task automatic test_abort_and_blocked_start();
    @(negedge clk);
    cfg_linear = 1'b1; cfg_len = 3'b011; start_addr = 16'h100; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0; addr_ready = 1'b1;
    @(negedge clk);
    check(int'(addr_out), 16'h101, "R6", "second word");
    chip_en_n = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    check(int'(addr_valid), 0, "R11", "fixed burst aborted");
    check(int'(burst_done), 0, "R11", "no done after abort");
    start_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(addr_valid), 0, "R2", "request ignored while chip enable off");
    start_valid = 1'b0; chip_en_n = 1'b0;
    @(negedge clk);
    check(int'(addr_valid), 0, "R2", "no stale request taken");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_four_word_all_offsets();
    test_long_lengths();
    test_reserved_codes();
    test_continuous();
    test_abort_and_blocked_start();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule